// File: doc/BRIEF.md
# Narrow-Access Register Write Merger

This block sits between a bus master that may issue 8-bit, 16-bit or 32-bit accesses and a peripheral register file that only understands whole 32-bit words. Each upstream request is turned into zero, one or two word-wide operations on a simple downstream read/write port. Read data on that port is combinational: it is valid in the same cycle as the read request.

Each register word falls into one of three classes, picked by comparing the word address against two parameter lists. The first class is ordinary storage. A narrow write to it becomes a read-modify-write: the current word is fetched, the addressed lanes are replaced and the word is written back. The second class holds write-one-to-clear status words and set/clear aliases. A narrow write to it becomes a single word write that carries the placed data with zeros in every other lane, so no bit outside the addressed lanes is cleared or set. The third class is read-only words, and narrow writes to them are dropped. Narrow reads return the word at the aligned address shifted down by the byte offset. Full-word accesses of either direction pass through untouched.

Top module: `narrow_write_merger`

## Requirements
- R1: While reset is held and while no request is pending, `ds_req` and `up_ready` are low.
- R2: A 32-bit access (`up_size` = 2 or 3) makes exactly one downstream operation with the same direction, data and aligned address. `up_ready` is high in that same cycle, for any register class.
- R3: A narrow write to a storage-class word makes a downstream read in the first cycle with `up_ready` low. In the next cycle it makes a downstream write of the merged word to the same address with `up_ready` high.
- R4: The byte offset is `up_addr[1:0]`. Data is placed at bit 8×offset. The lane mask is 0xFF for `up_size` = 0 (byte) and 0xFFFF for `up_size` = 1 (halfword), shifted by the same amount, and lanes shifted past bit 31 are discarded.
- R5: A narrow write to a zero-fill-class word is one downstream write whose data is the placed lanes, with zeros in all other bits. No downstream read is made.
- R6: A narrow write to a read-only-class word completes in one cycle with no downstream operation, so the stored word is unchanged.
- R7: A narrow read is one downstream read. `up_rdata` is the fetched word shifted right by 8×offset.
- R8: `ds_addr` always has bits [1:0] equal to zero.
- R9: Bits of `up_wdata` above the access width are ignored on narrow writes of both write classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request, held until `up_ready` |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Byte address |
| up_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| up_wdata | input | 32 | Write data, narrow data right-aligned |
| up_rdata | output | 32 | Read data, valid when `up_ready` |
| up_ready | output | 1 | Access completes at this clock edge |
| ds_req | output | 1 | Downstream operation this cycle |
| ds_we | output | 1 | Downstream write enable |
| ds_addr | output | AW | Word-aligned downstream address |
| ds_wdata | output | 32 | Downstream write word |
| ds_rdata | input | 32 | Downstream read word, same cycle |

## Verification
The bench goes after halfword writes at offset 3. Here half the lane falls off the top of the word, and a design with an unclipped or misaligned mask would corrupt bytes 0 to 2. It writes narrow data with junk in the upper bits, which a design that placed data without masking would smear into neighbouring lanes. For the zero-fill class, it preloads all ones and checks that the other lanes come back zero. A design that merged there would keep the old ones, which for a clear alias means bits get cleared by accident. It also counts downstream operations per access. A merge without the stalled read cycle, a read-only write that leaks through, or a word access that wrongly takes two cycles all show up as wrong counts.

// File: rtl/nwm_pkg.sv
package nwm_pkg;
  localparam int DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef enum logic [1:0] {CL_STORE = 2'd0, CL_ZERO = 2'd1, CL_RDONLY = 2'd2} reg_class_e;

  function automatic logic is_narrow(input logic [1:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF);
  endfunction

  // lanes covered by a narrow access, clipped at the top of the word
  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [DW-1:0] base;
    base = (sz == SZ_BYTE) ? 32'h0000_00FF : 32'h0000_FFFF;
    return base << {off, 3'b000};
  endfunction

  function automatic logic [DW-1:0] place(input logic [DW-1:0] d, input logic [1:0] sz,
                                          input logic [1:0] off);
    return (d << {off, 3'b000}) & lane_mask(sz, off);
  endfunction

  function automatic logic [DW-1:0] extract(input logic [DW-1:0] w, input logic [1:0] off);
    return w >> {off, 3'b000};
  endfunction
endpackage

// File: rtl/nwm_class_decode.sv
module nwm_class_decode
  import nwm_pkg::*;
#(
  parameter int AW = 8,
  parameter int N_RO = 2,
  parameter int N_ZF = 3,
  parameter logic [N_RO*AW-1:0] RO_LIST = '0,
  parameter logic [N_ZF*AW-1:0] ZF_LIST = '0
) (
  input  logic [AW-3:0] word_idx,
  output reg_class_e    cls
);
  logic [N_RO-1:0] ro_hit;
  logic [N_ZF-1:0] zf_hit;

  for (genvar gi = 0; gi < N_RO; gi++) begin : g_ro
    localparam logic [AW-1:0] ENT = RO_LIST[gi*AW +: AW];
    assign ro_hit[gi] = (word_idx == ENT[AW-1:2]);
  end

  for (genvar gi = 0; gi < N_ZF; gi++) begin : g_zf
    localparam logic [AW-1:0] ENT = ZF_LIST[gi*AW +: AW];
    assign zf_hit[gi] = (word_idx == ENT[AW-1:2]);
  end

  // read-only wins if a word is listed twice
  always_comb begin
    if (|ro_hit)      cls = CL_RDONLY;
    else if (|zf_hit) cls = CL_ZERO;
    else              cls = CL_STORE;
  end
endmodule

// File: rtl/nwm_lane_merge.sv
module nwm_lane_merge
  import nwm_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic [DW-1:0] new_data,
  input  logic [DW-1:0] cur_word,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] zero_filled,
  output logic [DW-1:0] read_shifted
);
  logic [DW-1:0] mask;

  assign mask         = lane_mask(size, off);
  assign zero_filled  = place(new_data, size, off);
  assign merged       = (cur_word & ~mask) | zero_filled;
  assign read_shifted = extract(cur_word, off);
endmodule

// File: rtl/nwm_ctrl.sv
module nwm_ctrl
  import nwm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          up_we,
  input  logic          narrow,
  input  reg_class_e    cls,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] up_wdata,
  input  logic [DW-1:0] zf_data,
  input  logic [DW-1:0] merged,
  output logic          ds_req,
  output logic          ds_we,
  output logic [AW-1:0] ds_addr,
  output logic [DW-1:0] ds_wdata,
  output logic          up_ready,
  output logic          wb_busy,
  output logic          rmw_start
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WBACK = 1'b1} st_e;

  st_e           state;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  assign wb_busy = (state == ST_WBACK);

  always_comb begin
    ds_req    = 1'b0;
    ds_we     = 1'b0;
    ds_addr   = word_addr;
    ds_wdata  = '0;
    up_ready  = 1'b0;
    rmw_start = 1'b0;
    if (wb_busy) begin
      ds_req   = 1'b1;
      ds_we    = 1'b1;
      ds_addr  = hold_addr;
      ds_wdata = hold_data;
      up_ready = 1'b1;
    end else if (up_req) begin
      if (!up_we) begin
        ds_req   = 1'b1;
        up_ready = 1'b1;
      end else if (!narrow) begin
        ds_req   = 1'b1;
        ds_we    = 1'b1;
        ds_wdata = up_wdata;
        up_ready = 1'b1;
      end else begin
        case (cls)
          CL_RDONLY: up_ready = 1'b1;
          CL_ZERO: begin
            ds_req   = 1'b1;
            ds_we    = 1'b1;
            ds_wdata = zf_data;
            up_ready = 1'b1;
          end
          default: begin
            ds_req    = 1'b1;
            rmw_start = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (rmw_start) begin
      state     <= ST_WBACK;
      hold_addr <= word_addr;
      hold_data <= merged;
    end else begin
      state     <= ST_IDLE;
    end
  end

  // R3: the fetch cycle is followed by a write-back to the same word
  assert_rmw_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> (ds_req && ds_we && up_ready && ds_addr == $past(ds_addr)));

  // R3: the fetch cycle is a stalled read
  assert_rmw_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |-> (ds_req && !ds_we && !up_ready));
endmodule

// File: rtl/narrow_write_merger.sv
module narrow_write_merger
  import nwm_pkg::*;
#(
  parameter int AW = 8,
  parameter int N_RO = 2,
  parameter int N_ZF = 3,
  parameter logic [N_RO*AW-1:0] RO_LIST = {8'h04, 8'h00},
  parameter logic [N_ZF*AW-1:0] ZF_LIST = {8'h18, 8'h14, 8'h10}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_req,
  input  logic          up_we,
  input  logic [AW-1:0] up_addr,
  input  logic [1:0]    up_size,
  input  logic [31:0]   up_wdata,
  output logic [31:0]   up_rdata,
  output logic          up_ready,
  output logic          ds_req,
  output logic          ds_we,
  output logic [AW-1:0] ds_addr,
  output logic [31:0]   ds_wdata,
  input  logic [31:0]   ds_rdata
);
  logic [1:0]    off;
  logic [AW-1:0] word_addr;
  logic          narrow;
  reg_class_e    cls;
  logic [DW-1:0] merged, zf_data, rd_shifted;
  logic          wb_busy, rmw_start;

  assign off       = up_addr[1:0];
  assign word_addr = {up_addr[AW-1:2], 2'b00};
  assign narrow    = is_narrow(up_size);

  nwm_class_decode #(
    .AW(AW), .N_RO(N_RO), .N_ZF(N_ZF), .RO_LIST(RO_LIST), .ZF_LIST(ZF_LIST)
  ) u_decode (
    .word_idx (up_addr[AW-1:2]),
    .cls      (cls)
  );

  nwm_lane_merge u_merge (
    .size         (up_size),
    .off          (off),
    .new_data     (up_wdata),
    .cur_word     (ds_rdata),
    .merged       (merged),
    .zero_filled  (zf_data),
    .read_shifted (rd_shifted)
  );

  nwm_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req    (up_req),
    .up_we     (up_we),
    .narrow    (narrow),
    .cls       (cls),
    .word_addr (word_addr),
    .up_wdata  (up_wdata),
    .zf_data   (zf_data),
    .merged    (merged),
    .ds_req    (ds_req),
    .ds_we     (ds_we),
    .ds_addr   (ds_addr),
    .ds_wdata  (ds_wdata),
    .up_ready  (up_ready),
    .wb_busy   (wb_busy),
    .rmw_start (rmw_start)
  );

  assign up_rdata = narrow ? rd_shifted : ds_rdata;

  // R8: downstream addresses are word aligned
  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req |-> (ds_addr[1:0] == 2'b00));

  // R6: a narrow write to a read-only word never reaches the port
  assert_ro_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && up_we && narrow && !wb_busy && cls == CL_RDONLY) |-> (!ds_req && up_ready));

  // R5: zero-fill writes carry nothing outside the addressed lanes
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && up_we && narrow && !wb_busy && cls == CL_ZERO)
      |-> (ds_we && ((ds_wdata & ~lane_mask(up_size, off)) == '0)));

  // R2: a full-word access never stalls
  assert_word_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !narrow && !wb_busy) |-> (up_ready && ds_req && ds_we == up_we));
endmodule

// File: tb/narrow_write_merger_tb.sv
`timescale 1ns/1ps
module narrow_write_merger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 1'b0, up_we = 1'b0;
  logic [7:0]  up_addr = '0;
  logic [1:0]  up_size = '0;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic        up_ready, ds_req, ds_we;
  logic [7:0]  ds_addr;
  logic [31:0] ds_wdata, ds_rdata;

  logic [31:0] mem [0:63];
  logic [31:0] ref_mem [0:63];
  int ds_ops = 0, ds_wrs = 0, misalign = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  narrow_write_merger u_dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
    .up_size(up_size), .up_wdata(up_wdata), .up_rdata(up_rdata), .up_ready(up_ready),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata)
  );

  assign ds_rdata = mem[ds_addr[7:2]];

  always @(posedge clk) begin
    if (rst_n && ds_req) begin
      ds_ops <= ds_ops + 1;
      if (ds_addr[1:0] != 2'b00) misalign <= misalign + 1;
      if (ds_we) begin
        mem[ds_addr[7:2]] <= ds_wdata;
        ds_wrs <= ds_wrs + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // byte-by-byte restatement of the lane update
  function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [31:0] d,
                                            input int nbytes, input int off, input bit zf);
    logic [31:0] r;
    r = zf ? 32'h0 : old;
    for (int k = 0; k < nbytes; k++)
      if (off + k < 4) r[(off + k) * 8 +: 8] = d[k * 8 +: 8];
    return r;
  endfunction

  int          a_cyc, a_ops, a_wrs;
  logic [31:0] a_rd;

  task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd);
    int o0, w0;
    @(negedge clk);
    o0 = ds_ops; w0 = ds_wrs;
    up_req = 1'b1; up_we = we; up_addr = addr; up_size = sz; up_wdata = wd;
    a_cyc = 0;
    forever begin
      #1;
      a_cyc++;
      if (up_ready) begin
        a_rd = up_rdata;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    up_req = 1'b0; up_we = 1'b0;
    a_ops = ds_ops - o0;
    a_wrs = ds_wrs - w0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ds_req in reset", {31'b0, ds_req}, 32'h0);
    chk("R1 up_ready in reset", {31'b0, up_ready}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 ds_req idle", {31'b0, ds_req}, 32'h0);
    chk("R1 up_ready idle", {31'b0, up_ready}, 32'h0);
  endtask

  task automatic t_word();
    access(1'b1, 8'h20, 2'd2, 32'hDEAD_BEEF); ref_mem[8] = 32'hDEAD_BEEF;
    chk("R2 word write cycles", a_cyc, 1);
    chk("R2 word write ops", a_ops, 1);
    chk("R2 word write value", mem[8], ref_mem[8]);
    access(1'b0, 8'h20, 2'd3, 32'h0);
    chk("R2 word read data", a_rd, 32'hDEAD_BEEF);
    chk("R2 word read ops", a_ops, 1);
    access(1'b1, 8'h04, 2'd2, 32'h1234_5678); ref_mem[1] = 32'h1234_5678;
    chk("R2 word write to read-only class", mem[1], ref_mem[1]);
    access(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF); ref_mem[4] = 32'hFFFF_FFFF;
    chk("R2 word write to zero-fill class", mem[4], ref_mem[4]);
  endtask

  task automatic t_rmw();
    for (int off = 0; off < 4; off++) begin
      logic [31:0] d;
      d = 32'hC3C3_C300 | 32'(8'h11 * (off + 1));
      access(1'b1, 8'h24 + 8'(off), 2'd0, d);
      ref_mem[9] = exp_write(ref_mem[9], d, 1, off, 1'b0);
      chk($sformatf("R3 R4 R9 byte merge off=%0d", off), mem[9], ref_mem[9]);
      chk($sformatf("R3 byte merge ops off=%0d", off), a_ops, 2);
      chk($sformatf("R3 byte merge cycles off=%0d", off), a_cyc, 2);
    end
    for (int off = 0; off < 4; off++) begin
      logic [31:0] d;
      d = 32'h7E7E_0000 | 32'(16'hA0B0 + 16'(off));
      access(1'b1, 8'h2C + 8'(off), 2'd1, d);
      ref_mem[11] = exp_write(ref_mem[11], d, 2, off, 1'b0);
      chk($sformatf("R4 R9 half merge off=%0d", off), mem[11], ref_mem[11]);
      chk($sformatf("R3 half merge writes off=%0d", off), a_wrs, 1);
    end
  endtask

  task automatic t_zero();
    access(1'b1, 8'h12, 2'd0, 32'hFFFF_FF5A);
    ref_mem[4] = exp_write(ref_mem[4], 32'hFFFF_FF5A, 1, 2, 1'b1);
    chk("R5 R9 byte zero fill", mem[4], ref_mem[4]);
    chk("R5 byte zero fill ops", a_ops, 1);
    chk("R5 byte zero fill cycles", a_cyc, 1);
    access(1'b1, 8'h17, 2'd1, 32'h0000_9966);
    ref_mem[5] = exp_write(ref_mem[5], 32'h0000_9966, 2, 3, 1'b1);
    chk("R5 R4 half zero fill off=3", mem[5], ref_mem[5]);
  endtask

  task automatic t_rdonly();
    access(1'b1, 8'h05, 2'd0, 32'h0000_0099);
    chk("R6 read-only word unchanged", mem[1], ref_mem[1]);
    chk("R6 read-only ops", a_ops, 0);
    chk("R6 read-only cycles", a_cyc, 1);
    access(1'b1, 8'h02, 2'd1, 32'h0000_4321);
    chk("R6 read-only half unchanged", mem[0], ref_mem[0]);
  endtask

  task automatic t_read();
    for (int off = 0; off < 4; off++) begin
      access(1'b0, 8'h24 + 8'(off), 2'(off & 1), 32'h0);
      chk($sformatf("R7 narrow read off=%0d", off), a_rd, ref_mem[9] >> (8 * off));
      chk($sformatf("R7 narrow read ops off=%0d", off), a_ops, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h5A00_0000 | 32'(i * 32'h0101);
      ref_mem[i] = mem[i];
    end
    t_reset();
    t_word();
    t_rmw();
    t_zero();
    t_rdonly();
    t_read();
    chk("R8 misaligned downstream addresses", misalign, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule